// File: doc/BRIEF.md
# Adjacent Line Pair Prefetcher

This block sits next to a second-level cache and watches the requests that look up its tags. Memory is treated as 128-byte blocks aligned on 128-byte boundaries, and each block holds two 64-byte cache lines. When a qualifying request misses, the block asks the memory request port to fetch the other line of the same block (its buddy). A qualifying request has write-back memory type and comes from one of the accepted sources: a demand access, a software prefetch, the first-level data prefetcher, or a stride prefetcher whose own request missed.

The prefetch leaves through a valid/ready channel. One prefetch can wait there. While the channel is stalled, a newer trigger overwrites the waiting one, so the request side is never stalled. A table of eight outstanding line addresses drops any prefetch that is already in flight. An entry is released when the memory port reports completion for that address.

Top module: `adj_pair_prefetch`

## Requirements
- R1: The prefetch line address equals the trigger address with bit 6 inverted and bits 5:0 cleared, so it is always 64-byte aligned.
- R2: Only memory type code 3'b110 (write-back) can trigger. Every other code (0 to 5 and 7) produces no prefetch.
- R3: Source codes 0 (demand access), 1 (software prefetch), 2 (first-level prefetcher) and 3 (stride prefetcher miss) trigger. Codes 4 to 7 never trigger.
- R4: A request that arrives with `lookup_hit` high produces no prefetch.
- R5: The prefetch address lies in the same 4 KB page as the trigger address: bits 31:12 are equal.
- R6: A qualifying miss sampled at a clock edge makes `pf_valid` high with the buddy address directly after that edge, provided a table slot is free.
- R7: A trigger is dropped when its buddy address is already held in the outstanding table or in the waiting register.
- R8: A `done_valid` pulse whose `done_addr` matches a table entry frees that entry, so the same line can be prefetched again.
- R9: While `pf_valid` is high and `pf_ready` is low, the waiting prefetch is held. A new qualifying trigger replaces it, and the replaced address is never issued.
- R10: When all eight table entries are occupied, `pf_valid` stays low and the waiting prefetch is kept. It is offered the cycle after an entry is freed.
- R11: A synchronous active-high `rst` clears both the waiting register and the outstanding table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A cache request is presented this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_src | input | 3 | Request source code (see R3) |
| req_memtype | input | 3 | Memory type code (see R2) |
| lookup_hit | input | 1 | Tag lookup result for the request, high on a hit |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Memory request port accepts the offered prefetch |
| pf_addr | output | 32 | Line address of the offered prefetch |
| done_valid | input | 1 | Memory port reports a prefetch completion |
| done_addr | input | 32 | Line address of the completed prefetch |

## Verification
A stale or wrong outstanding entry shows at the ports as a missing prefetch, or as a duplicate one, on the first trigger for that line after the fault. Each such trigger therefore has to be followed by a check on the very next cycle, and freed lines have to be re-triggered. A corrupted waiting register shows one cycle after it is loaded as a wrong `pf_addr`, or as `pf_valid` falling during a stall. The bench checks that cycle, and it also checks that a replaced address never comes out later. Filling the table shows whether the full condition gates the offer, and whether it releases the offer exactly one cycle after a completion.

// File: rtl/adj_pair_prefetch.sv
module adj_pair_prefetch #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int N_OUT     = 8,
  parameter int SRC_W     = 3,
  parameter int MT_W      = 3,
  parameter int N_TRIG_SRC = 4,
  parameter logic [MT_W-1:0] WB_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [MT_W-1:0]   req_memtype,
  input  logic              lookup_hit,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              done_valid,
  input  logic [ADDR_W-1:0] done_addr
);
  localparam int PAIR_BIT = LINE_BITS;

  logic              pend_v;
  logic [ADDR_W-1:0] pend_a;
  logic [N_OUT-1:0]  ent_v;
  logic [ADDR_W-1:0] ent_a [N_OUT];
  logic [N_OUT-1:0]  hit_new, hit_done, match_out, alloc_oh;
  logic [ADDR_W-1:0] buddy;
  logic              trig, dup, has_free, fire, found;
  logic [LINE_BITS-1:0] unused_low;

  assign unused_low = req_addr[LINE_BITS-1:0];

  assign buddy = {req_addr[ADDR_W-1:PAIR_BIT+1], ~req_addr[PAIR_BIT], {LINE_BITS{1'b0}}};

  assign trig = req_valid && !lookup_hit && (req_memtype == WB_CODE)
                && (int'(req_src) < N_TRIG_SRC);

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_ent
      assign hit_new[g]   = ent_v[g] && (ent_a[g] == buddy);
      assign hit_done[g]  = ent_v[g] && done_valid && (ent_a[g] == done_addr);
      assign match_out[g] = ent_v[g] && (ent_a[g] == pend_a);

      always_ff @(posedge clk) begin
        if (rst) begin
          ent_v[g] <= 1'b0;
          ent_a[g] <= '0;
        end else if (fire && alloc_oh[g]) begin
          ent_v[g] <= 1'b1;
          ent_a[g] <= pend_a;
        end else if (hit_done[g]) begin
          ent_v[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    alloc_oh = '0;
    found    = 1'b0;
    for (int i = 0; i < N_OUT; i++) begin
      if (!ent_v[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign has_free = !(&ent_v);
  assign dup      = (|hit_new) || (pend_v && (pend_a == buddy));
  assign pf_valid = pend_v && has_free;
  assign pf_addr  = pend_a;
  assign fire     = pf_valid && pf_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_a <= '0;
    end else if (trig && !dup) begin
      pend_v <= 1'b1;
      pend_a <= buddy;
    end else if (fire) begin
      pend_v <= 1'b0;
    end
  end
endmodule

module adj_pair_prefetch_chk #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int N_OUT     = 8,
  parameter int SRC_W     = 3,
  parameter int MT_W      = 3,
  parameter int N_TRIG_SRC = 4,
  parameter logic [MT_W-1:0] WB_CODE = 3'b110
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SRC_W-1:0]  req_src,
  input logic [MT_W-1:0]   req_memtype,
  input logic              lookup_hit,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              pend_v,
  input logic [N_OUT-1:0]  match_out
);
  AST_BUDDY_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_v) |-> (pf_addr[ADDR_W-1:LINE_BITS] == {$past(req_addr[ADDR_W-1:LINE_BITS+1]), ~$past(req_addr[LINE_BITS])})); // R1
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[LINE_BITS-1:0] == '0)); // R1
  AST_NON_WB_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_memtype != WB_CODE && !pend_v) |=> !pend_v); // R2
  AST_SRC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_src) >= N_TRIG_SRC && !pend_v) |=> !pend_v); // R3
  AST_HIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lookup_hit && !pend_v) |=> !pend_v); // R4
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_v) |-> (pf_addr[ADDR_W-1:PAGE_BITS] == $past(req_addr[ADDR_W-1:PAGE_BITS]))); // R5
  AST_NO_DUP_OUT: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> $countones(match_out) == 0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !(pf_valid && pf_ready)) |=> pend_v); // R9
endmodule

bind adj_pair_prefetch adj_pair_prefetch_chk #(
  .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS), .N_OUT(N_OUT),
  .SRC_W(SRC_W), .MT_W(MT_W), .N_TRIG_SRC(N_TRIG_SRC), .WB_CODE(WB_CODE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_src(req_src), .req_memtype(req_memtype), .lookup_hit(lookup_hit),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .pend_v(pend_v), .match_out(match_out)
);

// File: tb/adj_pair_prefetch_tb_top.sv
`timescale 1ns/1ps
module adj_pair_prefetch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_src = '0;
  logic [2:0]  req_memtype = '0;
  logic        lookup_hit = 1'b0;
  logic        pf_valid;
  logic        pf_ready = 1'b0;
  logic [31:0] pf_addr;
  logic        done_valid = 1'b0;
  logic [31:0] done_addr = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adj_pair_prefetch dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_src(req_src), .req_memtype(req_memtype), .lookup_hit(lookup_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .done_valid(done_valid), .done_addr(done_addr)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic [2:0]  mt;
    logic        hit;
    logic [31:0] addr;
    logic        ev;
    logic [31:0] ea;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd6, 1'b0, 32'h0000_1000, 1'b1, 32'h0000_1040, 8'd1},  // R1 lower line
    '{3'd0, 3'd6, 1'b0, 32'h0000_1047, 1'b1, 32'h0000_1000, 8'd1},  // R1 upper line
    '{3'd1, 3'd6, 1'b0, 32'h2345_6789, 1'b1, 32'h2345_67C0, 8'd3},  // R3 software prefetch
    '{3'd2, 3'd6, 1'b0, 32'h0000_ABC0, 1'b1, 32'h0000_AB80, 8'd3},  // R3 first-level prefetcher
    '{3'd3, 3'd6, 1'b0, 32'h0000_5000, 1'b1, 32'h0000_5040, 8'd3},  // R3 stride miss
    '{3'd4, 3'd6, 1'b0, 32'h0000_5100, 1'b0, 32'h0,         8'd3},  // R3 code 4
    '{3'd7, 3'd6, 1'b0, 32'h0000_5200, 1'b0, 32'h0,         8'd3},  // R3 code 7
    '{3'd0, 3'd0, 1'b0, 32'h0000_5300, 1'b0, 32'h0,         8'd2},  // R2 type 0
    '{3'd0, 3'd4, 1'b0, 32'h0000_5400, 1'b0, 32'h0,         8'd2},  // R2 type 4
    '{3'd0, 3'd7, 1'b0, 32'h0000_5500, 1'b0, 32'h0,         8'd2},  // R2 type 7
    '{3'd0, 3'd6, 1'b1, 32'h0000_5600, 1'b0, 32'h0,         8'd4},  // R4 hit
    '{3'd0, 3'd6, 1'b0, 32'h0000_1FC5, 1'b1, 32'h0000_1F80, 8'd5},  // R5 page top
    '{3'd2, 3'd6, 1'b0, 32'h0000_2FFF, 1'b1, 32'h0000_2F80, 8'd5}   // R5 page top
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] s, input logic [2:0] m, input logic h, input logic [31:0] a);
    req_valid = 1'b1; req_src = s; req_memtype = m; lookup_hit = h; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; lookup_hit = 1'b0;
  endtask

  task automatic send_wb(input logic [31:0] a);
    send(3'd0, 3'd6, 1'b0, a);
  endtask

  task automatic take();
    pf_ready = 1'b1;
    @(negedge clk);
    pf_ready = 1'b0;
  endtask

  task automatic done(input logic [31:0] a);
    done_valid = 1'b1; done_addr = a;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic expect_pf(input string tag, input logic [31:0] a);
    chk(pf_valid === 1'b1, {tag, " valid"}, {31'd0, pf_valid}, 32'd1);
    chk(pf_addr === a, {tag, " addr"}, pf_addr, a);
  endtask

  task automatic expect_none(input string tag);
    chk(pf_valid === 1'b0, tag, {31'd0, pf_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) idle();
    expect_none("R11 reset state");
    rst = 1'b0;
    idle();

    // Vector walk: R6 output one edge after the trigger
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].src, VECS[i].mt, VECS[i].hit, VECS[i].addr);
      if (VECS[i].ev) begin
        expect_pf($sformatf("R%0d/R6 vector %0d", VECS[i].rq, i), VECS[i].ea);
        take();
        expect_none($sformatf("R6 vector %0d cleared", i));
        done(VECS[i].ea);
      end else begin
        expect_none($sformatf("R%0d vector %0d no prefetch", VECS[i].rq, i));
        idle();
        expect_none($sformatf("R%0d vector %0d stays idle", VECS[i].rq, i));
      end
    end

    // R7 duplicate held in table, R8 freeing
    send_wb(32'h0000_3000); expect_pf("R7 first", 32'h0000_3040); take();
    send_wb(32'h0000_3000); expect_none("R7 table duplicate dropped");
    send_wb(32'h0000_3040); expect_pf("R7 other line distinct", 32'h0000_3000); take();
    done(32'h0000_3040);
    send_wb(32'h0000_3000); expect_pf("R8 reissue after completion", 32'h0000_3040); take();
    done(32'h0000_3040); done(32'h0000_3000);

    // R7 duplicate of waiting register
    send_wb(32'h0000_4000); send_wb(32'h0000_4010);
    expect_pf("R7 waiting duplicate", 32'h0000_4040);
    take(); expect_none("R7 single issue");
    done(32'h0000_4040);

    // R9 stall hold and replacement
    send_wb(32'h0000_6000); idle(); idle();
    expect_pf("R9 held during stall", 32'h0000_6040);
    send_wb(32'h0000_7000); expect_pf("R9 replaced", 32'h0000_7040);
    take(); expect_none("R9 replaced address not issued");
    done(32'h0000_7040);
    send_wb(32'h0000_6000); expect_pf("R9 replaced line never entered table", 32'h0000_6040);
    take(); done(32'h0000_6040);

    // R10 full table
    for (int k = 0; k < 8; k++) begin
      send_wb(32'h0001_0000 + k * 32'h80); take();
    end
    send_wb(32'h0002_0000); expect_none("R10 full table gates offer");
    idle(); expect_none("R10 still gated");
    done(32'h0001_0040); expect_pf("R10 offered after free", 32'h0002_0040);
    take();
    for (int k = 1; k < 8; k++) done(32'h0001_0040 + k * 32'h80);
    done(32'h0002_0040);

    // R11 reset clears waiting register and table
    send_wb(32'h0000_8000); take();
    send_wb(32'h0000_9000); expect_pf("R11 pre-reset waiting", 32'h0000_9040);
    rst = 1'b1; idle(); expect_none("R11 waiting cleared");
    rst = 1'b0; idle(); expect_none("R11 idle after reset");
    send_wb(32'h0000_8000); expect_pf("R11 table cleared", 32'h0000_8040);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule